// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets synchronous on-chip logic use an external asynchronous static RAM organised as 262,144 words of 16 bits. It drives an 18-bit address and five active-low strobes: chip select, read-output enable, write strobe and one select per byte lane. The data path to the pads is split into an output word, an input word and a drive enable for the tri-state pad cells. The memory has no clock, so every analog timing limit is turned into a whole number of system clock cycles. Each count comes from a clock-period parameter and is rounded up.

The user side has a level request and a one-cycle acknowledge. The requester presents a request with its address, write word, two-bit lane mask and direction, and holds them until the acknowledge. It may then drop the request, or keep it high with new fields to chain the next access. A chained access is accepted only once the previous one has fully finished, including the idle time the memory needs to release the data bus after a read. Read data comes back with a valid pulse in the same cycle as the acknowledge.

Top module: `sram_ctl`

## Requirements
- R1: While reset is low, and until the first accepted request, sram_ce_n, sram_oe_n and sram_we_n are 1, sram_bsel_n is 2'b11, and sram_dq_oe, ack and rd_valid are 0.
- R2: A read (req_we=0) holds sram_ce_n=0, sram_oe_n=0, sram_we_n=1 and sram_addr=req_addr for RD_CYC consecutive cycles, where RD_CYC is ceil(45 ns / clock period), which is 6 at 125 MHz. The memory word is sampled at the end of the last of these cycles, and ack and rd_valid rise together in the next cycle. From an idle controller, ack comes RD_CYC+1 cycles after req is first seen.
- R3: Lane mask bit 0 selects data bits 7:0 and drives sram_bsel_n[0] low. Bit 1 selects bits 15:8 and drives sram_bsel_n[1] low. The selects are held for the whole access.
- R4: In rd_data, a lane whose mask bit is 0 reads as 8'h00, and a lane whose mask bit is 1 carries the memory contents.
- R5: A write (req_we=1) holds sram_ce_n=0 and sram_we_n=0 for WR_CYC cycles, where WR_CYC is ceil(35 ns / clock period), which is 5 at 125 MHz. During this time sram_dq_oe=1, sram_dq_o=req_wdata, and the address and lane selects stay constant. Only the lanes that are enabled change in memory. From an idle controller, ack comes WR_CYC+1 cycles after req is first seen.
- R6: sram_dq_oe is 1 only while sram_we_n is 0, plus one hold cycle after sram_we_n rises. During the hold cycle the address and chip select are unchanged and ack is pulsed.
- R7: After a read, sram_dq_oe does not rise until at least TURN_CYC cycles after sram_oe_n rises, where TURN_CYC is ceil(15 ns / clock period), which is 2 at 125 MHz. That is at least 15 ns.
- R8: Each request gets exactly one ack, and ack lasts one cycle. rd_valid is high only with the ack of a read. If req stays high after an ack, the next access is accepted TURN_CYC+1 cycles after a read's ack, or 2 cycles after a write's ack, and never earlier.
- R9: A request with lane mask 2'b00 runs the normal cycle with sram_bsel_n=2'b11 throughout. A write of this kind leaves memory unchanged, and a read of this kind returns 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ack | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | rd_data is valid (read completions only) |
| rd_data | output | 16 | Read word, unselected lanes zero |
| sram_addr | output | 18 | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Read-output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_bsel_n | output | 2 | Lane selects, active low, bit 0 lower lane |
| sram_dq_o | output | 16 | Word to the pad drivers |
| sram_dq_oe | output | 1 | Pad driver enable |
| sram_dq_i | input | 16 | Word from the pads |

## Verification
A wait counter that is loaded or decremented wrongly shows up at the acknowledge of the very access it corrupts. The acknowledge arrives on a different cycle from the one the bench predicts. For reads, the memory model also returns a junk pattern until 45 ns have passed, so sampling too early gives wrong read data on the first read. A wrong lane-mapping state shows within the same access, either as a select pattern that does not match the mask or as a non-zero unselected lane in rd_data. A state machine that skips the hold or turnaround phase makes the pad driver enable rise too close to the read-enable release, or fall too soon after the write strobe. The bench measures both in nanoseconds, on the next write.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RD    = 3'd1,
      ST_RTURN = 3'd2,
      ST_WR    = 3'd3,
      ST_WHOLD = 3'd4
   } sc_state_e;

   // Whole clock cycles covering a delay, never below one.
   function automatic int unsigned ps_to_cyc(input int unsigned t_ps,
                                             input int unsigned clk_ps);
      int unsigned c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      return (c == 0) ? 1 : c;
   endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // the counter never leaves the range it was loaded into
   timer_dec_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (!load && $past(cnt_q) != '0 && !$past(load)) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_lane_map.sv
`timescale 1ns/1ps
module sram_lane_map #(
   parameter int unsigned LANES = 2
) (
   input  logic [LANES-1:0]   be,
   input  logic [LANES*8-1:0] bus_in,
   output logic [LANES-1:0]   bsel_n,
   output logic [LANES*8-1:0] bus_masked
);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign bsel_n[g]            = ~be[g];
         assign bus_masked[g*8 +: 8] = be[g] ? bus_in[g*8 +: 8] : 8'h00;
      end
   endgenerate

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl #(
   parameter int unsigned ADDR_W        = 18,
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned CLK_PERIOD_PS = 8000,
   parameter int unsigned T_ACC_PS      = 45000,
   parameter int unsigned T_TURN_PS     = 15000,
   parameter int unsigned T_WP_PS       = 35000,
   localparam int unsigned LANES        = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              ack,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_oe_n,
   output logic              sram_we_n,
   output logic [LANES-1:0]  sram_bsel_n,
   output logic [DATA_W-1:0] sram_dq_o,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_i
);
   import sram_ctl_pkg::*;

   localparam int unsigned RD_CYC   = ps_to_cyc(T_ACC_PS,  CLK_PERIOD_PS);
   localparam int unsigned TURN_CYC = ps_to_cyc(T_TURN_PS, CLK_PERIOD_PS);
   localparam int unsigned WR_CYC   = ps_to_cyc(T_WP_PS,   CLK_PERIOD_PS);
   localparam int unsigned MAX_CYC  = (RD_CYC > WR_CYC) ?
                                      ((RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC) :
                                      ((WR_CYC > TURN_CYC) ? WR_CYC : TURN_CYC);
   localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WR_LD   = CNT_W'(WR_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("sram_ctl: ADDR_W must be at least 1");
      end
      if (DATA_W == 0 || (DATA_W % 8) != 0) begin : g_bad_data
         $error("sram_ctl: DATA_W must be a non-zero multiple of 8");
      end
      if (CLK_PERIOD_PS == 0) begin : g_bad_clk
         $error("sram_ctl: CLK_PERIOD_PS must be non-zero");
      end
   endgenerate

   sc_state_e         state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  be_q, be_d;
   logic              accept;
   logic              tmr_load, tmr_exp, cap, wr_done, in_cycle_d;
   logic [CNT_W-1:0]  tmr_val;
   logic [LANES-1:0]  bsel_act_n;
   logic [DATA_W-1:0] rd_masked;

   assign accept = (state_q == ST_IDLE) && req;
   assign be_d   = accept ? req_be : be_q;

   sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   sram_lane_map #(.LANES(LANES)) u_lanes (
      .be         (be_d),
      .bus_in     (sram_dq_i),
      .bsel_n     (bsel_act_n),
      .bus_masked (rd_masked)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      cap      = 1'b0;
      wr_done  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req) begin
               tmr_load = 1'b1;
               if (req_we) begin
                  state_d = ST_WR;
                  tmr_val = WR_LD;
               end else begin
                  state_d = ST_RD;
                  tmr_val = RD_LD;
               end
            end
         end
         ST_RD: begin
            if (tmr_exp) begin
               cap      = 1'b1;
               state_d  = ST_RTURN;
               tmr_load = 1'b1;
               tmr_val  = TURN_LD;
            end
         end
         ST_RTURN: begin
            if (tmr_exp) state_d = ST_IDLE;
         end
         ST_WR: begin
            if (tmr_exp) begin
               wr_done = 1'b1;
               state_d = ST_WHOLD;
            end
         end
         ST_WHOLD: state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   assign in_cycle_d = (state_d == ST_RD) || (state_d == ST_WR) || (state_d == ST_WHOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         wdata_q     <= '0;
         be_q        <= '0;
         sram_ce_n   <= 1'b1;
         sram_oe_n   <= 1'b1;
         sram_we_n   <= 1'b1;
         sram_bsel_n <= '1;
         sram_dq_oe  <= 1'b0;
         ack         <= 1'b0;
         rd_valid    <= 1'b0;
         rd_data     <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
         end
         sram_ce_n   <= !in_cycle_d;
         sram_oe_n   <= (state_d != ST_RD);
         sram_we_n   <= (state_d != ST_WR);
         sram_dq_oe  <= (state_d == ST_WR) || (state_d == ST_WHOLD);
         sram_bsel_n <= in_cycle_d ? bsel_act_n : '1;
         ack         <= cap || wr_done;
         rd_valid    <= cap;
         if (cap) rd_data <= rd_masked;
      end
   end

   assign sram_addr = addr_q;
   assign sram_dq_o = wdata_q;

   // ---------------- checks next to the logic ----------------
   logic [CNT_W:0] acc_cnt;
   logic [CNT_W:0] oe_hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_cnt   <= '0;
         oe_hi_cnt <= (CNT_W+1)'(TURN_CYC + 1);
      end else begin
         if (sram_oe_n || sram_ce_n) acc_cnt <= '0;
         else if (acc_cnt < (CNT_W+1)'(RD_CYC)) acc_cnt <= acc_cnt + 1'b1;
         if (!sram_oe_n) oe_hi_cnt <= '0;
         else if (oe_hi_cnt < (CNT_W+1)'(TURN_CYC + 1)) oe_hi_cnt <= oe_hi_cnt + 1'b1;
      end
   end

   // R2
   rd_access_time_chk : assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (acc_cnt >= (CNT_W+1)'(RD_CYC)));

   // R2
   rd_strobe_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> (sram_we_n && !sram_ce_n && !sram_dq_oe));

   // R5
   wr_stable_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_we_n && $past(!sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_bsel_n)));

   // R6
   drive_window_chk : assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> (!sram_we_n || !$past(sram_we_n)));

   // R7
   turnaround_chk : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_dq_oe) |-> (oe_hi_cnt >= (CNT_W+1)'(TURN_CYC)));

   // R8
   ack_pulse_chk : assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   // R8
   rdv_with_ack_chk : assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ack);

endmodule

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;

   localparam int NL = 2;
   function automatic int cdiv(input int a, input int b);
      return (a + b - 1) / b;
   endfunction
   localparam int CLK_NS = 8;
   localparam int RD_C   = cdiv(45, CLK_NS);
   localparam int WR_C   = cdiv(35, CLK_NS);
   localparam int TURN_C = cdiv(15, CLK_NS);

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req, req_we;
   logic [17:0] req_addr;
   logic [15:0] req_wdata;
   logic [1:0]  req_be;
   logic        ack, rd_valid;
   logic [15:0] rd_data;
   logic [17:0] sram_addr;
   logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
   logic [1:0]  sram_bsel_n;
   logic [15:0] sram_dq_o, sram_dq_i;

   sram_ctl dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rd_valid(rd_valid),
      .rd_data(rd_data), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
      .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_bsel_n(sram_bsel_n),
      .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
   );

   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0, n_req = 0, ack_seen = 0;
   bit finished = 1'b0;
   logic [1:0]  cur_be = 2'b00;
   logic [15:0] last_rd;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s act=%h exp=%h t=%0t", rq, what, act, exp, $time);
      end
   endtask

   // ---------------- memory model ----------------
   logic [15:0] mem [int];
   logic [15:0] shadow [int];

   function automatic logic [15:0] seed_word(input int a);
      return 16'((a * 40503) ^ 16'h3C5A ^ (a >>> 7));
   endfunction
   function automatic logic [15:0] mem_get(input int a);
      return mem.exists(a) ? mem[a] : seed_word(a);
   endfunction
   function automatic logic [15:0] sh_get(input int a);
      return shadow.exists(a) ? shadow[a] : seed_word(a);
   endfunction
   function automatic logic [15:0] lane_mask(input logic [1:0] be, input logic [15:0] w);
      return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
   endfunction

   realtime t_chg = 0.0;
   always @(sram_addr or sram_ce_n or sram_oe_n or sram_we_n or sram_bsel_n)
      t_chg = $realtime;

   initial begin
      sram_dq_i = 16'hDEAD;
      #0.5;
      forever begin
         logic [15:0] w, m;
         #1;
         w = 16'hDEAD;
         if (!sram_ce_n && sram_we_n && !sram_oe_n && ($realtime - t_chg) >= 45.0) begin
            m = mem_get(int'(sram_addr));
            for (int l = 0; l < NL; l++)
               if (!sram_bsel_n[l]) w[l*8 +: 8] = m[l*8 +: 8];
         end
         sram_dq_i = w;
      end
   end

   realtime     t_we_fall = 0.0;
   logic [17:0] wa;
   logic [1:0]  wb;
   always @(negedge sram_we_n) if (rst_n === 1'b1) begin
      t_we_fall = $realtime;
      wa = sram_addr;
      wb = sram_bsel_n;
   end

   always @(posedge sram_we_n) if (rst_n === 1'b1 && !sram_ce_n) begin
      logic [15:0] m;
      chk(sram_addr == wa, "R5", "addr moved in write pulse", 32'(sram_addr), 32'(wa));
      chk(sram_bsel_n == wb, "R5", "selects moved in write pulse", 32'(sram_bsel_n), 32'(wb));
      chk(sram_bsel_n == ~cur_be, "R3", "write lane selects", 32'(sram_bsel_n), 32'(~cur_be));
      if (cur_be == 2'b00)
         chk(sram_bsel_n == 2'b11, "R9", "empty mask selects", 32'(sram_bsel_n), 32'h3);
      chk(sram_dq_oe == 1'b1, "R6", "driver on at strobe rise", 32'(sram_dq_oe), 32'h1);
      chk(($realtime - t_we_fall) >= real'(WR_C * CLK_NS), "R5", "write pulse ns",
          32'(int'($realtime - t_we_fall)), 32'(WR_C * CLK_NS));
      m = mem_get(int'(sram_addr));
      for (int l = 0; l < NL; l++)
         if (!sram_bsel_n[l]) m[l*8 +: 8] = sram_dq_o[l*8 +: 8];
      mem[int'(sram_addr)] = m;
      #4;
      chk(sram_dq_oe && !sram_ce_n && sram_addr == wa, "R6", "hold cycle",
          {sram_dq_oe, sram_ce_n, 12'h0, sram_addr}, {1'b1, 1'b0, 12'h0, wa});
      #8;
      chk(sram_dq_oe == 1'b0, "R6", "driver released after hold", 32'(sram_dq_oe), 32'h0);
   end

   realtime t_oe_rise = -1000.0;
   always @(posedge sram_oe_n) t_oe_rise = $realtime;
   always @(posedge sram_dq_oe) if (rst_n === 1'b1) begin
      chk(sram_oe_n == 1'b1, "R7", "driver with read enable", 32'(sram_oe_n), 32'h1);
      chk(($realtime - t_oe_rise) >= 15.0, "R7", "turnaround ns",
          32'(int'($realtime - t_oe_rise)), 32'd15);
   end

   always @(negedge clk) if (rst_n === 1'b1 && ack) ack_seen++;

   // ---------------- transaction task ----------------
   task automatic do_req(input bit we, input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] be, input bit chained, input bit prev_rd);
      int lat_exp, cnt, base;
      logic [15:0] exp_rd;
      string rq;
      if (!chained) @(negedge clk);
      req = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
      cur_be = be;
      n_req++;
      base    = we ? WR_C : RD_C;
      lat_exp = chained ? (base + (prev_rd ? TURN_C + 1 : 2)) : (base + 1);
      exp_rd  = lane_mask(be, sh_get(int'(a)));
      rq      = chained ? "R8" : (we ? "R5" : "R2");
      cnt = 0;
      forever begin
         @(negedge clk);
         cnt++;
         if (cnt == lat_exp - 1) begin
            if (we) begin
               chk(!sram_we_n && !sram_ce_n && sram_dq_oe, "R5", "write strobes",
                   {sram_we_n, sram_ce_n, sram_dq_oe}, 32'h1);
               chk(sram_dq_o == d, "R5", "write word", 32'(sram_dq_o), 32'(d));
               chk(sram_addr == a, "R5", "write addr", 32'(sram_addr), 32'(a));
            end else begin
               chk(!sram_ce_n && !sram_oe_n && sram_we_n && !sram_dq_oe, "R2", "read strobes",
                   {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 32'h2);
               chk(sram_addr == a, "R2", "read addr", 32'(sram_addr), 32'(a));
               chk(sram_bsel_n == ~be, "R3", "read lane selects", 32'(sram_bsel_n), 32'(~be));
            end
         end
         if (ack || cnt > lat_exp + 20) break;
      end
      chk(ack && cnt == lat_exp, rq, "ack latency", 32'(cnt), 32'(lat_exp));
      if (we) begin
         chk(rd_valid == 1'b0, "R8", "rd_valid on write", 32'(rd_valid), 32'h0);
         begin
            logic [15:0] s;
            s = sh_get(int'(a));
            for (int l = 0; l < NL; l++)
               if (be[l]) s[l*8 +: 8] = d[l*8 +: 8];
            shadow[int'(a)] = s;
         end
      end else begin
         chk(rd_valid == 1'b1, "R2", "rd_valid on read", 32'(rd_valid), 32'h1);
         chk(rd_data == exp_rd, (be == 2'b11) ? "R2" : "R4", "read word",
             32'(rd_data), 32'(exp_rd));
         last_rd = rd_data;
      end
   endtask

   task automatic drop_req();
      req = 1'b0;
      @(negedge clk);
      chk(!ack && !rd_valid, "R8", "single ack pulse", {ack, rd_valid}, 32'h0);
   endtask

   // ---------------- main ----------------
   initial begin
      bit prev_rd, chain;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
      repeat (3) @(negedge clk);
      chk(sram_ce_n && sram_oe_n && sram_we_n && sram_bsel_n == 2'b11 && !sram_dq_oe
          && !ack && !rd_valid, "R1", "pins in reset",
          {sram_ce_n, sram_oe_n, sram_we_n, sram_bsel_n, sram_dq_oe, ack, rd_valid},
          32'b1111_1000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(sram_ce_n && sram_oe_n && sram_we_n && sram_bsel_n == 2'b11 && !sram_dq_oe
          && !ack && !rd_valid, "R1", "pins idle after reset",
          {sram_ce_n, sram_oe_n, sram_we_n, sram_bsel_n, sram_dq_oe, ack, rd_valid},
          32'b1111_1000);

      // directed corner cases
      do_req(1'b1, 18'h00000, 16'h1234, 2'b11, 1'b0, 1'b0); drop_req();
      do_req(1'b0, 18'h00000, 16'h0000, 2'b11, 1'b0, 1'b0); drop_req();
      chk(last_rd == 16'h1234, "R2", "full word readback", 32'(last_rd), 32'h1234);
      do_req(1'b1, 18'h3FFFF, 16'hABCD, 2'b01, 1'b0, 1'b0); drop_req();
      do_req(1'b1, 18'h3FFFF, 16'h5566, 2'b10, 1'b0, 1'b0); drop_req();
      do_req(1'b0, 18'h3FFFF, 16'h0000, 2'b11, 1'b0, 1'b0); drop_req();
      chk(last_rd == 16'h55CD, "R5", "lane-wise writes merge", 32'(last_rd), 32'h55CD);
      do_req(1'b1, 18'h00000, 16'hFFFF, 2'b00, 1'b0, 1'b0); drop_req();
      do_req(1'b0, 18'h00000, 16'h0000, 2'b11, 1'b0, 1'b0); drop_req();
      chk(last_rd == 16'h1234, "R9", "empty-mask write left memory", 32'(last_rd), 32'h1234);
      do_req(1'b0, 18'h00000, 16'h0000, 2'b00, 1'b0, 1'b0); drop_req();
      chk(last_rd == 16'h0000, "R9", "empty-mask read", 32'(last_rd), 32'h0);
      do_req(1'b0, 18'h00000, 16'h0000, 2'b01, 1'b0, 1'b0); drop_req();
      chk(last_rd == 16'h0034, "R4", "lower lane only", 32'(last_rd), 32'h0034);
      do_req(1'b0, 18'h00000, 16'h0000, 2'b10, 1'b0, 1'b0); drop_req();
      chk(last_rd == 16'h1200, "R4", "upper lane only", 32'(last_rd), 32'h1200);
      // chained: read, write right after, read again
      do_req(1'b0, 18'h00000, 16'h0000, 2'b11, 1'b0, 1'b0);
      do_req(1'b1, 18'h00001, 16'hC0DE, 2'b11, 1'b1, 1'b1);
      do_req(1'b0, 18'h00001, 16'h0000, 2'b11, 1'b1, 1'b0);
      chk(last_rd == 16'hC0DE, "R8", "chained write then read", 32'(last_rd), 32'hC0DE);
      drop_req();

      // constrained random mix
      chain = 1'b0; prev_rd = 1'b0;
      for (int i = 0; i < 300; i++) begin
         bit we;
         logic [17:0] a;
         logic [1:0]  be;
         we = ($urandom % 2) == 1;
         a  = (($urandom % 4) == 0) ? 18'($urandom) : 18'($urandom % 16);
         be = (($urandom % 8) == 0) ? 2'b00 : 2'(1 + ($urandom % 3));
         do_req(we, a, 16'($urandom), be, chain, prev_rd);
         prev_rd = !we;
         chain = ($urandom % 3) == 0;
         if (!chain) begin
            drop_req();
            repeat ($urandom % 3) @(negedge clk);
         end
      end
      if (chain) drop_req();
      repeat (4) @(negedge clk);
      chk(ack_seen == n_req, "R8", "acks per request", 32'(ack_seen), 32'(n_req));

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * CLK_NS);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R8 watchdog act=running exp=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule